// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

This block keeps a free-running time count for a precision-time-protocol clock. On every clock cycle while it runs, the count grows by a programmable step. A fractional frequency trim is built in: once every N running cycles, a separate correction step is added instead of the normal step. Software can speed the count up or slow it down this way without changing the base step.

The count either rolls over at its full binary width or, in period mode, folds back by a programmable wrap value. Every wrap raises a one-cycle pulse, and a second output can repeat that pulse as an event when software enables it. Software reaches the block through a small word-addressed register port. It reads the count by first writing a snapshot command and then reading the latched copy. It can write a new count directly, and it can restart the count from zero.

Register map (word addresses):

| Address | Write effect | Read result |
|---|---|---|
| 0 | control register | control register |
| 1 | loads the count | the snapshot |
| 2 | wrap value | wrap value |
| 3 | trim period, written as N-1 | trim period |
| 4 | step register: normal step in bits [6:0], correction step in bits [14:8] | step register |

Control register bits:

| Bit | Function |
|---|---|
| 0 | run |
| 1 | restart |
| 2 | snapshot |
| 3 | period mode |
| 4 | wrap-event enable |

Top module: `adj_time_counter`

## Requirements
- R1: After reset, the count, the snapshot and every register read back as zero, and wrap_pulse and wrap_event are low.
- R2: The count changes on each clock edge at which control bit 0 (run) was already 1, and no earlier. A write that sets run starts counting at the next edge. A write that clears run still lets the count advance once at its own edge. While run is 0 and nothing is written, the count holds.
- R3: When the trim period register (address 3) holds a nonzero value N-1, every N-th running cycle adds the correction step (address 4, bits [14:8]) in place of the normal step (address 4, bits [6:0]). The cycle count that chooses the correction step starts over when the trim period is written or a restart is issued.
- R4: When the trim period is zero, every running cycle adds the normal step, whatever the correction step holds.
- R5: With control bit 3 (period mode) set, a step whose sum reaches or passes the wrap value (address 2) leaves the count at the sum minus the wrap value. A sum that exactly equals the wrap value gives zero.
- R6: With period mode clear, the count wraps modulo 2^CNT_W.
- R7: Every edge at which the count wraps makes wrap_pulse high for the following cycle only. wrap_event does the same, but only when control bit 4 is set; otherwise it stays low.
- R8: A control write with bit 2 set copies the count as it was before that edge into the snapshot. A read of address 1 returns the snapshot. A running count is not disturbed by the copy.
- R9: A write to address 1 loads the written value into the count at that edge.
- R10: A control write with bit 1 set zeroes the count at that edge.
- R11: Restart (bit 1) and snapshot (bit 2) read back as 1 for the one cycle after the write and as 0 after that. Bits 0, 3 and 4 read back as written.
- R12: rd_data is registered and valid on the cycle after rd_en. Addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | reference clock, one tick per cycle |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe |
| addr | input | ADDR_W | register word address |
| wr_data | input | DATA_W | write data |
| rd_data | output | DATA_W | registered read data |
| wrap_pulse | output | 1 | one-cycle pulse after each wrap |
| wrap_event | output | 1 | wrap pulse gated by the event enable |

## Verification
A wrong step choice or a drifting trim count shows up in the next snapshot as a value off by a multiple of the step difference, within the N cycles of one trim period. A wrong fold-back in period mode leaves a visible remainder, and a wrong wrap decision shows up as a missing or extra pulse in the cycle right after the wrapping edge. Self-clearing control bits that fail to clear are visible on the second read of the control register.

// File: rtl/adj_tc_pkg.sv
package adj_tc_pkg;
  // register word addresses
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_TIME = 1;
  localparam int unsigned A_WRAP = 2;
  localparam int unsigned A_TRIM = 3;
  localparam int unsigned A_STEP = 4;

  // control bit positions
  localparam int unsigned C_RUN     = 0;
  localparam int unsigned C_RESTART = 1;
  localparam int unsigned C_SNAP    = 2;
  localparam int unsigned C_PERIOD  = 3;
  localparam int unsigned C_EVENT   = 4;

  // step register field positions
  localparam int unsigned STEP_N_LSB = 0;
  localparam int unsigned STEP_C_LSB = 8;

  typedef struct packed {
    logic event_en;
    logic period_mode;
    logic run;
  } mode_t;
endpackage

// File: rtl/adj_tc_regs.sv
module adj_tc_regs
  import adj_tc_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7,
  parameter int TRIM_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  snapshot,
  output logic [DATA_W-1:0] rd_data,
  output mode_t             mode,
  output logic              restart_p,
  output logic              snap_p,
  output logic              load_p,
  output logic              trim_wr_p,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  wrap_val,
  output logic [TRIM_W-1:0] trim_val,
  output logic [STEP_W-1:0] step_norm,
  output logic [STEP_W-1:0] step_corr
);
  logic wr_ctrl, wr_wrap, wr_step;
  logic restart_flag, snap_flag;
  logic [DATA_W-1:0] rd_next;

  assign wr_ctrl   = wr_en && (addr == ADDR_W'(A_CTRL));
  assign load_p    = wr_en && (addr == ADDR_W'(A_TIME));
  assign wr_wrap   = wr_en && (addr == ADDR_W'(A_WRAP));
  assign trim_wr_p = wr_en && (addr == ADDR_W'(A_TRIM));
  assign wr_step   = wr_en && (addr == ADDR_W'(A_STEP));
  assign restart_p = wr_ctrl && wr_data[C_RESTART];
  assign snap_p    = wr_ctrl && wr_data[C_SNAP];
  assign load_val  = wr_data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode         <= '0;
      restart_flag <= 1'b0;
      snap_flag    <= 1'b0;
      wrap_val     <= '0;
      trim_val     <= '0;
      step_norm    <= '0;
      step_corr    <= '0;
    end else begin
      restart_flag <= restart_p;
      snap_flag    <= snap_p;
      if (wr_ctrl) begin
        mode.run         <= wr_data[C_RUN];
        mode.period_mode <= wr_data[C_PERIOD];
        mode.event_en    <= wr_data[C_EVENT];
      end
      if (wr_wrap)   wrap_val <= wr_data[CNT_W-1:0];
      if (trim_wr_p) trim_val <= wr_data[TRIM_W-1:0];
      if (wr_step) begin
        step_norm <= wr_data[STEP_N_LSB +: STEP_W];
        step_corr <= wr_data[STEP_C_LSB +: STEP_W];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      ADDR_W'(A_CTRL): begin
        rd_next[C_RUN]     = mode.run;
        rd_next[C_RESTART] = restart_flag;
        rd_next[C_SNAP]    = snap_flag;
        rd_next[C_PERIOD]  = mode.period_mode;
        rd_next[C_EVENT]   = mode.event_en;
      end
      ADDR_W'(A_TIME): rd_next = DATA_W'(snapshot);
      ADDR_W'(A_WRAP): rd_next = DATA_W'(wrap_val);
      ADDR_W'(A_TRIM): rd_next = DATA_W'(trim_val);
      ADDR_W'(A_STEP): begin
        rd_next[STEP_N_LSB +: STEP_W] = step_norm;
        rd_next[STEP_C_LSB +: STEP_W] = step_corr;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/adj_tc_trim.sv
module adj_tc_trim #(
  parameter int STEP_W = 7,
  parameter int TRIM_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart_p,
  input  logic              trim_wr_p,
  input  logic [TRIM_W-1:0] trim_val,
  input  logic [STEP_W-1:0] step_norm,
  input  logic [STEP_W-1:0] step_corr,
  output logic [STEP_W-1:0] step
);
  logic [TRIM_W-1:0] tick_cnt;
  logic trim_on, hit;

  assign trim_on = (trim_val != '0);
  assign hit     = trim_on && (tick_cnt == trim_val);
  assign step    = hit ? step_corr : step_norm;

  always_ff @(posedge clk) begin
    if (rst || restart_p || trim_wr_p) tick_cnt <= '0;
    else if (run && trim_on)           tick_cnt <= hit ? '0 : tick_cnt + TRIM_W'(1);
  end
endmodule

// File: rtl/adj_tc_accum.sv
module adj_tc_accum #(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              period_mode,
  input  logic              event_en,
  input  logic [STEP_W-1:0] step,
  input  logic [CNT_W-1:0]  wrap_val,
  input  logic              restart_p,
  input  logic              snap_p,
  input  logic              load_p,
  input  logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  snapshot,
  output logic              wrap_pulse,
  output logic              wrap_event
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] sum, folded;
  logic [CNT_W-1:0] nxt;
  logic over;

  assign sum    = {1'b0, count} + SUM_W'(step);
  assign folded = sum - {1'b0, wrap_val};

  always_comb begin
    if (period_mode) begin
      over = (sum >= {1'b0, wrap_val});
      nxt  = over ? folded[CNT_W-1:0] : sum[CNT_W-1:0];
    end else begin
      over = sum[CNT_W];
      nxt  = sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      snapshot   <= '0;
      wrap_pulse <= 1'b0;
      wrap_event <= 1'b0;
    end else begin
      wrap_pulse <= 1'b0;
      wrap_event <= 1'b0;
      if (snap_p) snapshot <= count;
      if (load_p)         count <= load_val;
      else if (restart_p) count <= '0;
      else if (run) begin
        count      <= nxt;
        wrap_pulse <= over;
        wrap_event <= over && event_en;
      end
    end
  end
endmodule

// File: rtl/adj_time_counter.sv
module adj_time_counter
  import adj_tc_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7,
  parameter int TRIM_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              wrap_pulse,
  output logic              wrap_event
);
  mode_t             mode;
  logic              restart_p, snap_p, load_p, trim_wr_p;
  logic [CNT_W-1:0]  load_val, wrap_val, snapshot, count_q;
  logic [TRIM_W-1:0] trim_val;
  logic [STEP_W-1:0] step_norm, step_corr, step;
  logic              run_w;

  assign run_w = mode.run;

  adj_tc_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .STEP_W(STEP_W), .TRIM_W(TRIM_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .snapshot(snapshot), .rd_data(rd_data), .mode(mode),
    .restart_p(restart_p), .snap_p(snap_p), .load_p(load_p),
    .trim_wr_p(trim_wr_p), .load_val(load_val), .wrap_val(wrap_val),
    .trim_val(trim_val), .step_norm(step_norm), .step_corr(step_corr)
  );

  adj_tc_trim #(.STEP_W(STEP_W), .TRIM_W(TRIM_W)) u_trim (
    .clk(clk), .rst(rst), .run(run_w), .restart_p(restart_p),
    .trim_wr_p(trim_wr_p), .trim_val(trim_val), .step_norm(step_norm),
    .step_corr(step_corr), .step(step)
  );

  adj_tc_accum #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_accum (
    .clk(clk), .rst(rst), .run(run_w), .period_mode(mode.period_mode),
    .event_en(mode.event_en), .step(step), .wrap_val(wrap_val),
    .restart_p(restart_p), .snap_p(snap_p), .load_p(load_p),
    .load_val(load_val), .count(count_q), .snapshot(snapshot),
    .wrap_pulse(wrap_pulse), .wrap_event(wrap_event)
  );
endmodule

// File: rtl/adj_tc_checker.sv
module adj_tc_checker
  import adj_tc_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              wrap_pulse,
  input logic              wrap_event,
  input logic [CNT_W-1:0]  count,
  input logic              run
);
  assert_event_has_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    wrap_event |-> wrap_pulse);

  assert_wrap_needs_run_R2: assert property (@(posedge clk) disable iff (rst)
    wrap_pulse |-> $past(run));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en) |=> $stable(count));

  assert_load_value_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(A_TIME)) |=> (count == $past(wr_data[CNT_W-1:0])));

  assert_restart_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(A_CTRL) && wr_data[C_RESTART]) |=> (count == '0));

  assert_unused_reads_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr > ADDR_W'(A_STEP)) |=> (rd_data == '0));
endmodule

bind adj_time_counter adj_tc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .wrap_pulse(wrap_pulse),
  .wrap_event(wrap_event), .count(count_q), .run(run_w)
);

// File: tb/adj_time_counter_tb.sv
`timescale 1ns/1ps
module adj_time_counter_tb;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam logic [31:0] RUN = 32'h1, RST = 32'h2, SNAP = 32'h4,
                          PER = 32'h8, EVT = 32'h10;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic wrap_pulse, wrap_event;

  int checks = 0, fails = 0, pcnt = 0, ecnt = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  adj_time_counter u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .wrap_pulse(wrap_pulse),
    .wrap_event(wrap_event)
  );

  always @(negedge clk) if (!rst) begin
    if (wrap_pulse) pcnt++;
    if (wrap_event) ecnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = ADDR_W'(a); wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = ADDR_W'(a);
    @(posedge clk); #1 rd_en = 1'b0;
    @(negedge clk); d = rd_data;
  endtask

  task automatic run_ticks(input int n, input logic [31:0] m);
    wr(0, m | RUN);
    repeat (n - 1) @(posedge clk);
    wr(0, m);
  endtask

  task automatic snap_read(input logic [31:0] m, output logic [31:0] d);
    wr(0, m | SNAP);
    rd(1, d);
  endtask

  task automatic t_reset;
    chk("R1 pulse", {31'b0, wrap_pulse}, 0);
    chk("R1 event", {31'b0, wrap_event}, 0);
    rd(0, rv); chk("R1 ctrl", rv, 0);
    rd(1, rv); chk("R1 snapshot", rv, 0);
    rd(4, rv); chk("R1 step", rv, 0);
  endtask

  task automatic t_count;
    wr(4, 32'd5);
    run_ticks(7, 0);
    snap_read(0, rv); chk("R2 R8 seven ticks", rv, 35);
    repeat (5) @(posedge clk);
    snap_read(0, rv); chk("R2 hold when stopped", rv, 35);
  endtask

  task automatic t_snap_running;
    wr(0, RST);
    wr(0, RUN);                 // ticks from next edge
    repeat (3) @(posedge clk);  // 3 ticks -> 15
    wr(0, RUN | SNAP);          // snapshot 15, tick -> 20
    @(posedge clk);             // 25
    wr(0, 0);                   // 30
    rd(1, rv); chk("R8 snapshot while running", rv, 15);
    snap_read(0, rv); chk("R8 count undisturbed", rv, 30);
  endtask

  task automatic t_load;
    wr(1, 32'd1000);
    snap_read(0, rv); chk("R9 loaded value", rv, 1000);
    run_ticks(3, 0);
    snap_read(0, rv); chk("R9 counts from load", rv, 1015);
  endtask

  task automatic t_restart;
    wr(0, RST);
    rd(0, rv); chk("R11 restart flag set", rv, RST);
    rd(0, rv); chk("R11 restart flag cleared", rv, 0);
    wr(0, SNAP);
    rd(0, rv); chk("R11 snapshot flag set", rv, SNAP);
    rd(1, rv); chk("R10 count zeroed", rv, 0);
    wr(0, PER | EVT);
    rd(0, rv); chk("R11 mode bits read back", rv, PER | EVT);
    wr(0, 0);
  endtask

  task automatic t_trim;
    wr(0, RST);
    wr(4, (32'd13 << 8) | 32'd10);
    wr(3, 32'd3);
    run_ticks(8, 0);
    snap_read(0, rv); chk("R3 correction every 4th tick", rv, 86);
    run_ticks(4, 0);
    snap_read(0, rv); chk("R3 schedule continues", rv, 129);
    rd(4, rv); chk("R3 step fields", rv, 32'h0000_0D0A);
  endtask

  task automatic t_trim_zero;
    wr(0, RST);
    wr(3, 32'd0);
    run_ticks(8, 0);
    snap_read(0, rv); chk("R4 no correction", rv, 80);
  endtask

  task automatic t_period;
    int p0, e0;
    wr(4, 32'd10);
    wr(2, 32'd100);
    wr(1, 32'd75);
    p0 = pcnt; e0 = ecnt;
    run_ticks(3, PER | EVT);   // 85, 95, 5
    repeat (3) @(posedge clk);
    snap_read(PER | EVT, rv); chk("R5 remainder after wrap", rv, 5);
    chk("R7 one pulse", pcnt - p0, 1);
    chk("R7 one event", ecnt - e0, 1);
    wr(1, 32'd90);
    p0 = pcnt; e0 = ecnt;
    run_ticks(1, PER);         // 100 -> 0
    repeat (3) @(posedge clk);
    snap_read(PER, rv); chk("R5 exact wrap to zero", rv, 0);
    chk("R7 pulse without event", pcnt - p0, 1);
    chk("R7 event gated off", ecnt - e0, 0);
    wr(0, 0);
  endtask

  task automatic t_free;
    int p0;
    wr(1, 32'hFFFF_FFF0);
    p0 = pcnt;
    run_ticks(1, 0);
    repeat (3) @(posedge clk);
    snap_read(0, rv); chk("R6 below top", rv, 32'hFFFF_FFFA);
    chk("R6 no wrap pulse", pcnt - p0, 0);
    run_ticks(1, 0);
    repeat (3) @(posedge clk);
    snap_read(0, rv); chk("R6 modulo wrap", rv, 32'h0000_0004);
    chk("R7 free wrap pulse", pcnt - p0, 1);
  endtask

  task automatic t_read;
    rd(2, rv); chk("R12 wrap readback", rv, 100);
    for (int a = 5; a < 8; a++) begin
      rd(a, rv); chk("R12 unused address", rv, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_count;
    t_snap_running;
    t_load;
    t_restart;
    t_trim;
    t_trim_zero;
    t_period;
    t_free;
    t_read;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule